// File: doc/BRIEF.md
# Event-Linked I/O Port Selector

This block ties event pulses to the bits of one 8-bit I/O port. Events can reach the port in two ways. A single-bit link names one port and one bit. A group link names a set of bits in the port through a mask. Each bit's direction decides its role. Output bits are driven by incoming events. Changes on input bits raise outgoing event pulses.

There are four single-bit links. Each has a port field, a bit field and a 2-bit operation field. A link acts only when its port field matches the port number of this instance. A group is valid only when at least two mask bits are set. Masked output bits form the output group, and an event on the group input loads a preset pattern onto them. Masked input bits form the input group, and an edge on any of them raises the group event output.

When a bit is both a single-bit target and a group member, a fixed rule applies. An input bit serves both functions. An output bit serves only the group function, and its single-bit link is ignored.

Top module: `evlink_port`

## Requirements
- R1: The group is valid only when two or more bits of `grp_mask_i` are set. With fewer than two, `grp_evt_i` leaves `port_o` unchanged and `grp_evt_o` stays 0.
- R2: An event on `grp_evt_i` with a valid group loads `grp_preset_i` into every output group member bit of `port_o` on the next clock edge. All other bits are unchanged.
- R3: A pin edge on an input group member raises `grp_evt_o` for one cycle. `grp_edge_i` chooses the edge with the same encoding as R8. The pulse appears on the second rising edge after the pin changes.
- R4: An event on `lnk_evt_i[l]` for an active output link changes its bit on the next edge. The operation is set by `lnk_op_i` field l: 00 sets the bit, 01 clears it, 10 toggles it and 11 leaves it alone. With no event, `port_o` holds.
- R5: A link acts only when its 2-bit port field (`lnk_port_i` bits 2l+1:2l) equals parameter `PORT_ID` (default 1).
- R6: A single-bit output link whose target is an output group member of a valid group has no effect on `port_o`.
- R7: An input bit that is both a single-bit target and an input group member raises both `lnk_evt_o[l]` and `grp_evt_o` on the same edge.
- R8: A single-bit input link raises `lnk_evt_o[l]` for one cycle on a pin edge. The pulse appears on the second rising edge after the change. `lnk_op_i` field l selects the edge: 00 rising, 01 falling, 10 both, 11 none.
- R9: A bit is an output when its `dir_i` bit is 1. An output operation aimed at an input bit leaves `port_o` unchanged.
- R10: Synchronous active-high reset clears `port_o`, `lnk_evt_o` and `grp_evt_o`.
- R11: When several links act on the same bit in one cycle, they apply in rising link index order, so the highest index decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 8 | Bit direction, 1 = output |
| grp_mask_i | input | 8 | Group member mask |
| grp_preset_i | input | 8 | Pattern loaded onto output group members |
| grp_edge_i | input | 2 | Edge select for the input group |
| lnk_port_i | input | 8 | Port field of each link, 2 bits per link |
| lnk_bit_i | input | 12 | Bit field of each link, 3 bits per link |
| lnk_op_i | input | 8 | Operation or edge field of each link, 2 bits per link |
| lnk_evt_i | input | 4 | Event in, one per link |
| grp_evt_i | input | 1 | Event in for the output group |
| pin_i | input | 8 | Pin levels seen on the port |
| port_o | output | 8 | Registered output data |
| lnk_evt_o | output | 4 | Event out, one per input link |
| grp_evt_o | output | 1 | Event out for the input group |

## Verification
Output-side results are due one edge after the event. `port_o` is therefore checked half a cycle after the edge that follows the driven event. Input-side pulses are due on the second edge after a pin change, because the pin passes two sample registers. The bench model keeps the same two-stage pin history and compares `lnk_evt_o` and `grp_evt_o` after every edge. A missing pulse, an extra pulse or a pulse one cycle off is each caught. All inputs change on the falling edge, so each comparison sees settled values.

// File: rtl/evlink_pkg.sv
package evlink_pkg;
  localparam logic [1:0] OP_SET = 2'b00;
  localparam logic [1:0] OP_CLR = 2'b01;
  localparam logic [1:0] OP_TOG = 2'b10;
  localparam logic [1:0] OP_NOP = 2'b11;

  localparam logic [1:0] EDGE_RISE = 2'b00;
  localparam logic [1:0] EDGE_FALL = 2'b01;
  localparam logic [1:0] EDGE_BOTH = 2'b10;

  function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prev);
    case (sel)
      EDGE_RISE: edge_hit = cur & ~prev;
      EDGE_FALL: edge_hit = ~cur & prev;
      EDGE_BOTH: edge_hit = cur ^ prev;
      default:   edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/evlink_decode.sv
module evlink_decode #(
  parameter int W = 8,
  parameter int NL = 4,
  parameter int PSW = 2,
  parameter int BSW = $clog2(W),
  parameter int PORT_ID = 1
) (
  input  logic [W-1:0]      dir_i,
  input  logic [W-1:0]      mask_i,
  input  logic [NL*PSW-1:0] lnk_port_i,
  input  logic [NL*BSW-1:0] lnk_bit_i,
  output logic              grp_valid_o,
  output logic [W-1:0]      grp_in_o,
  output logic [W-1:0]      grp_out_o,
  output logic [NL-1:0]     out_en_o,
  output logic [NL-1:0]     in_en_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [PSW-1:0] MY_PORT = PSW'(PORT_ID);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int b = 0; b < W; b++) cnt = cnt + CW'(mask_i[b]);
  end

  assign grp_valid_o = (cnt >= CW'(2));
  assign grp_in_o    = grp_valid_o ? (mask_i & ~dir_i) : '0;
  assign grp_out_o   = grp_valid_o ? (mask_i & dir_i) : '0;

  for (genvar l = 0; l < NL; l++) begin : g_lnk
    logic [BSW-1:0] tgt;
    logic           sel;
    assign tgt = lnk_bit_i[l*BSW +: BSW];
    assign sel = (lnk_port_i[l*PSW +: PSW] == MY_PORT);
    assign out_en_o[l] = sel & dir_i[tgt] & ~grp_out_o[tgt];
    assign in_en_o[l]  = sel & ~dir_i[tgt];
  end
endmodule

// File: rtl/evlink_out_drive.sv
module evlink_out_drive
  import evlink_pkg::*;
#(
  parameter int W = 8,
  parameter int NL = 4,
  parameter int BSW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grp_valid_i,
  input  logic [W-1:0]      grp_out_i,
  input  logic [W-1:0]      preset_i,
  input  logic              grp_evt_i,
  input  logic [NL-1:0]     out_en_i,
  input  logic [NL*BSW-1:0] lnk_bit_i,
  input  logic [NL*2-1:0]   lnk_op_i,
  input  logic [NL-1:0]     lnk_evt_i,
  output logic [W-1:0]      port_o
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = port_o;
    if (grp_evt_i && grp_valid_i) nxt = (nxt & ~grp_out_i) | (preset_i & grp_out_i);
    for (int l = 0; l < NL; l++) begin
      if (lnk_evt_i[l] && out_en_i[l]) begin
        case (lnk_op_i[l*2 +: 2])
          OP_SET:  nxt[lnk_bit_i[l*BSW +: BSW]] = 1'b1;
          OP_CLR:  nxt[lnk_bit_i[l*BSW +: BSW]] = 1'b0;
          OP_TOG:  nxt[lnk_bit_i[l*BSW +: BSW]] = ~nxt[lnk_bit_i[l*BSW +: BSW]];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) port_o <= '0;
    else     port_o <= nxt;
  end

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|lnk_evt_i) && !grp_evt_i) |=> $stable(port_o));
  // R2
  grp_load_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_evt_i && grp_valid_i) |=> (((port_o ^ $past(preset_i)) & $past(grp_out_i)) == '0));
  // R6
  grp_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !grp_evt_i |=> (((port_o ^ $past(port_o)) & $past(grp_out_i)) == '0));
endmodule

// File: rtl/evlink_in_detect.sv
module evlink_in_detect
  import evlink_pkg::*;
#(
  parameter int W = 8,
  parameter int NL = 4,
  parameter int BSW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      pin_i,
  input  logic [W-1:0]      grp_in_i,
  input  logic [1:0]        grp_edge_i,
  input  logic [NL-1:0]     in_en_i,
  input  logic [NL*BSW-1:0] lnk_bit_i,
  input  logic [NL*2-1:0]   lnk_op_i,
  output logic [NL-1:0]     lnk_evt_o,
  output logic              grp_evt_o
);
  logic [W-1:0] cur_q, prev_q;
  logic [W-1:0] grp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      cur_q  <= pin_i;
      prev_q <= cur_q;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign grp_hit[b] = grp_in_i[b] & edge_hit(grp_edge_i, cur_q[b], prev_q[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) grp_evt_o <= 1'b0;
    else     grp_evt_o <= |grp_hit;
  end

  for (genvar l = 0; l < NL; l++) begin : g_lnk
    logic [BSW-1:0] tgt;
    assign tgt = lnk_bit_i[l*BSW +: BSW];
    always_ff @(posedge clk) begin
      if (rst) lnk_evt_o[l] <= 1'b0;
      else     lnk_evt_o[l] <= in_en_i[l] & edge_hit(lnk_op_i[l*2 +: 2], cur_q[tgt], prev_q[tgt]);
    end
    // R8
    lnk_src_chk: assert property (@(posedge clk) disable iff (rst)
      lnk_evt_o[l] |-> $past(in_en_i[l]));
  end

  // R1
  grp_src_chk: assert property (@(posedge clk) disable iff (rst)
    grp_evt_o |-> $past(|grp_in_i));
endmodule

// File: rtl/evlink_port.sv
module evlink_port #(
  parameter int W = 8,
  parameter int NL = 4,
  parameter int PSW = 2,
  parameter int PORT_ID = 1,
  localparam int BSW = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      dir_i,
  input  logic [W-1:0]      grp_mask_i,
  input  logic [W-1:0]      grp_preset_i,
  input  logic [1:0]        grp_edge_i,
  input  logic [NL*PSW-1:0] lnk_port_i,
  input  logic [NL*BSW-1:0] lnk_bit_i,
  input  logic [NL*2-1:0]   lnk_op_i,
  input  logic [NL-1:0]     lnk_evt_i,
  input  logic              grp_evt_i,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      port_o,
  output logic [NL-1:0]     lnk_evt_o,
  output logic              grp_evt_o
);
  logic          grp_valid;
  logic [W-1:0]  grp_in, grp_out;
  logic [NL-1:0] out_en, in_en;

  evlink_decode #(.W(W), .NL(NL), .PSW(PSW), .BSW(BSW), .PORT_ID(PORT_ID)) u_dec (
    .dir_i(dir_i), .mask_i(grp_mask_i), .lnk_port_i(lnk_port_i), .lnk_bit_i(lnk_bit_i),
    .grp_valid_o(grp_valid), .grp_in_o(grp_in), .grp_out_o(grp_out),
    .out_en_o(out_en), .in_en_o(in_en));

  evlink_out_drive #(.W(W), .NL(NL), .BSW(BSW)) u_out (
    .clk(clk), .rst(rst), .grp_valid_i(grp_valid), .grp_out_i(grp_out),
    .preset_i(grp_preset_i), .grp_evt_i(grp_evt_i), .out_en_i(out_en),
    .lnk_bit_i(lnk_bit_i), .lnk_op_i(lnk_op_i), .lnk_evt_i(lnk_evt_i), .port_o(port_o));

  evlink_in_detect #(.W(W), .NL(NL), .BSW(BSW)) u_in (
    .clk(clk), .rst(rst), .pin_i(pin_i), .grp_in_i(grp_in), .grp_edge_i(grp_edge_i),
    .in_en_i(in_en), .lnk_bit_i(lnk_bit_i), .lnk_op_i(lnk_op_i),
    .lnk_evt_o(lnk_evt_o), .grp_evt_o(grp_evt_o));
endmodule

// File: tb/sim_evlink_port.sv
`timescale 1ns/1ps
module sim_evlink_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  dir_i = '0, grp_mask_i = '0, grp_preset_i = '0, pin_i = '0;
  logic [1:0]  grp_edge_i = '0;
  logic [7:0]  lnk_port_i = '0, lnk_op_i = '0;
  logic [11:0] lnk_bit_i = '0;
  logic [3:0]  lnk_evt_i = '0;
  logic        grp_evt_i = 1'b0;
  logic [7:0]  port_o;
  logic [3:0]  lnk_evt_o;
  logic        grp_evt_o;

  int checks = 0, fails = 0;
  bit done = 0;
  bit [7:0] m_port, m_q1, m_q2;
  bit [3:0] m_levt;
  bit       m_gevt;

  always #2 clk = ~clk;

  evlink_port u0 (.clk(clk), .rst(rst), .dir_i(dir_i), .grp_mask_i(grp_mask_i),
    .grp_preset_i(grp_preset_i), .grp_edge_i(grp_edge_i), .lnk_port_i(lnk_port_i),
    .lnk_bit_i(lnk_bit_i), .lnk_op_i(lnk_op_i), .lnk_evt_i(lnk_evt_i),
    .grp_evt_i(grp_evt_i), .pin_i(pin_i), .port_o(port_o), .lnk_evt_o(lnk_evt_o),
    .grp_evt_o(grp_evt_o));

  function automatic bit e_ok(bit [1:0] s, bit c, bit p);
    return (s == 2'b00) ? (c && !p) : (s == 2'b01) ? (!c && p) : (s == 2'b10) ? (c != p) : 1'b0;
  endfunction

  task automatic model_edge();
    bit gv; bit [7:0] go, gi, np; bit [2:0] t; bit sel;
    if (rst) begin
      m_port = 0; m_q1 = 0; m_q2 = 0; m_levt = 0; m_gevt = 0;
      return;
    end
    gv = $countones(grp_mask_i) >= 2;
    go = gv ? (grp_mask_i & dir_i) : 8'h00;
    gi = gv ? (grp_mask_i & ~dir_i) : 8'h00;
    np = m_port;
    if (grp_evt_i && gv) np = (np & ~go) | (grp_preset_i & go);
    for (int l = 0; l < 4; l++) begin
      t = lnk_bit_i[l*3 +: 3];
      sel = (lnk_port_i[l*2 +: 2] == 2'd1);
      if (lnk_evt_i[l] && sel && dir_i[t] && !go[t])
        case (lnk_op_i[l*2 +: 2])
          2'b00: np[t] = 1'b1;
          2'b01: np[t] = 1'b0;
          2'b10: np[t] = !np[t];
          default: ;
        endcase
      m_levt[l] = sel && !dir_i[t] && e_ok(lnk_op_i[l*2 +: 2], m_q1[t], m_q2[t]);
    end
    m_gevt = 0;
    for (int b = 0; b < 8; b++) if (gi[b] && e_ok(grp_edge_i, m_q1[b], m_q2[b])) m_gevt = 1;
    m_q2 = m_q1; m_q1 = pin_i; m_port = np;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (port_o !== m_port || lnk_evt_o !== m_levt || grp_evt_o !== m_gevt) begin
      fails++;
      $display("FAIL %s: port=%h lev=%b gev=%b expected port=%h lev=%b gev=%b",
               tag, port_o, lnk_evt_o, grp_evt_o, m_port, m_levt, m_gevt);
    end
  endtask

  task automatic set_link(int l, bit [1:0] p, bit [2:0] b, bit [1:0] op);
    lnk_port_i[l*2 +: 2] = p; lnk_bit_i[l*3 +: 3] = b; lnk_op_i[l*2 +: 2] = op;
  endtask

  task automatic fire(int l, string tag);
    lnk_evt_i[l] = 1'b1; step(tag); lnk_evt_i = '0;
  endtask

  initial begin
    int unused;
    unused = $urandom(7);
    step("R10 reset"); step("R10 reset");
    rst = 1'b0;
    for (int l = 0; l < 4; l++) set_link(l, 2'd0, 3'd0, 2'b11);
    dir_i = 8'hFF;
    step("R10 idle after reset");
    set_link(0, 2'd1, 3'd2, 2'b00); fire(0, "R4 set");
    if (port_o !== 8'h04) begin fails++; $display("FAIL R4: port=%h expected 04", port_o); end
    checks++;
    set_link(0, 2'd1, 3'd2, 2'b10); fire(0, "R4 toggle");
    set_link(0, 2'd1, 3'd2, 2'b10); fire(0, "R4 toggle back");
    set_link(0, 2'd1, 3'd2, 2'b11); fire(0, "R4 nop");
    set_link(0, 2'd1, 3'd2, 2'b01); fire(0, "R4 clear");
    set_link(0, 2'd2, 3'd5, 2'b00); fire(0, "R5 port mismatch");
    set_link(0, 2'd1, 3'd3, 2'b00); set_link(1, 2'd1, 3'd3, 2'b01);
    lnk_evt_i = 4'b0011; step("R11 same-bit order"); lnk_evt_i = '0;
    set_link(1, 2'd0, 3'd0, 2'b11);
    grp_mask_i = 8'h10; grp_preset_i = 8'hFF; grp_evt_i = 1; step("R1 one-bit mask"); grp_evt_i = 0;
    grp_mask_i = 8'h0F; grp_preset_i = 8'hA5; grp_evt_i = 1; step("R2 group load"); grp_evt_i = 0;
    set_link(0, 2'd1, 3'd1, 2'b10); fire(0, "R6 suppressed overlap");
    dir_i = 8'h7F; set_link(0, 2'd1, 3'd7, 2'b00); fire(0, "R9 input target");
    dir_i = 8'h00; grp_mask_i = 8'h06; grp_edge_i = 2'b00;
    set_link(0, 2'd1, 3'd1, 2'b00); step("R7 setup");
    pin_i = 8'h02; step("R7 edge seen"); step("R7 both pulses"); step("R7 pulse ends");
    set_link(0, 2'd1, 3'd1, 2'b01); pin_i = 8'h00;
    step("R8 falling"); step("R8 falling"); step("R8 falling");
    set_link(0, 2'd1, 3'd1, 2'b10); grp_edge_i = 2'b11; pin_i = 8'h02;
    step("R8 both"); step("R8 both"); step("R3 group none");
    set_link(0, 2'd1, 3'd1, 2'b11); grp_edge_i = 2'b01; pin_i = 8'h00;
    step("R3 group falling"); step("R3 group falling"); step("R8 none");
    for (int c = 0; c < 3000; c++) begin
      if (c % 64 == 0) begin
        dir_i = 8'($urandom); grp_mask_i = 8'($urandom); grp_preset_i = 8'($urandom);
        grp_edge_i = 2'($urandom); lnk_port_i = 8'($urandom);
        lnk_bit_i = 12'($urandom); lnk_op_i = 8'($urandom);
      end
      lnk_evt_i = 4'($urandom); grp_evt_i = 1'($urandom);
      pin_i = (($urandom % 4) == 0) ? 8'($urandom) : pin_i;
      step("R2 R3 R4 R6 R8 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule